// File: doc/BRIEF.md
# Multi-mode ADC channel scan sequencer

This block is the digital controller in front of a successive-approximation converter core. It walks the analog channel number upward from a programmed first channel to a programmed last channel. For each channel it issues a one-cycle start to the core, waits for the core's completion strobe, stores the sample in a result register and emits a one-cycle done pulse. The channel number counts modulo 16, so a first channel above the last channel wraps through 15 and 0.

A two-bit mode input selects one of four scan behaviours:

- a single-shot sweep that a new trigger can restart;
- a single-shot sweep that ignores triggers while it runs;
- an endless sweep;
- a pause mode that converts one channel per trigger.

A software trigger and an external trigger start a scan. A busy-clear request stops an endless or paused scan. A resolution input selects a full 10-bit result or a narrowed 8-bit result. If the resolution setting changes during a conversion, the stored result is flagged as not valid.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is applied, and until a trigger arrives after reset, busy, conv_start, done, result_ok and result are 0, and chan is 0.
- R2: In idle, a trigger (sw_trig or ext_trig high at a clock edge) sets busy, asserts conv_start and loads chan with first_ch, all in the cycle after that edge.
- R3: In the single-shot modes (mode 00 and 01), every channel from first_ch up to last_ch is converted exactly once, in order. Each conversion gets one conv_start pulse of one cycle, and the block waits for conv_done before it moves on. Busy drops in the cycle after conv_done for last_ch.
- R4: In mode 00, a trigger while the block waits for conv_done restarts the scan: conv_start is asserted with chan equal to first_ch in the next cycle.
- R5: In modes 01, 10 and 11, a trigger while a conversion is in progress has no effect on chan, conv_start or the converted sequence.
- R6: In mode 10, after last_ch is converted, scanning continues from first_ch with no new trigger.
- R7: In mode 11, each trigger converts one channel and the block then waits with busy high. The first trigger converts first_ch, and each later trigger converts the next channel. After last_ch, the next trigger converts first_ch.
- R8: In modes 10 and 11, busy_clr returns the block to idle (busy 0) in the next cycle, even when a trigger arrives in the same cycle. In modes 00 and 01, busy_clr is ignored.
- R9: With res8 = 0, result equals the 10-bit converter sample. With res8 = 1, result bits 7..0 equal sample bits 9..2 and result bits 9..8 are 0.
- R10: result_ok is 1 after a conversion during which res8 did not change. It is 0 if res8 at conv_done differs from res8 at conv_start.
- R11: done is a one-cycle pulse in the cycle after conv_done is accepted, and result already holds that conversion's value in that cycle.
- R12: Channel stepping is modulo 16, so first_ch greater than last_ch scans first_ch..15 then 0..last_ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Scan mode: 00 restartable single-shot, 01 single-shot, 10 continuous, 11 pause |
| res8 | input | 1 | 1 selects an 8-bit result, 0 selects 10-bit |
| first_ch | input | 4 | First channel of the scan |
| last_ch | input | 4 | Last channel of the scan |
| sw_trig | input | 1 | Software start trigger |
| ext_trig | input | 1 | External start trigger |
| busy_clr | input | 1 | Request to clear busy (forced stop) |
| conv_start | output | 1 | One-cycle start to the converter core |
| conv_done | input | 1 | Converter core completion strobe |
| conv_data | input | 10 | Converter core sample |
| chan | output | 4 | Channel being converted |
| result | output | 10 | Last stored result |
| result_ok | output | 1 | Stored result is valid |
| done | output | 1 | One-cycle pulse per finished conversion |
| busy | output | 1 | Scan active |

## Verification
The bench builds the block with its default parameters: a 4-bit channel field and a 10-bit sample. This keeps the whole space of first/last channel pairs small enough to sweep in full. All 256 pairs are run in both single-shot modes, which covers every wrap-around span and every span length from 1 to 16. The converter model answers after a latency that varies by channel. Its sample is a known function of the channel, so every stored result can be predicted in both resolutions. Directed runs then cover restart, ignored triggers, endless wrap, per-trigger pause stepping and forced stop.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    MODE_SHOT_RS = 2'b00,
    MODE_SHOT    = 2'b01,
    MODE_CONT    = 2'b10,
    MODE_PAUSE   = 2'b11
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_HOLD
  } scan_st_e;

  typedef enum logic [1:0] {
    CH_KEEP,
    CH_FIRST,
    CH_ADV
  } ch_op_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import adc_scan_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic [1:0] mode,
  input  logic     trig,
  input  logic     stop_req,
  input  logic     conv_done,
  input  logic     at_last,
  output ch_op_e   ch_op,
  output logic     capture,
  output logic     issue,
  output logic     active
);
  scan_st_e   st_q, st_d;
  scan_mode_e md;
  logic       stop_ok;

  assign md      = scan_mode_e'(mode);
  assign stop_ok = stop_req && (md == MODE_CONT || md == MODE_PAUSE);

  always_comb begin
    st_d    = st_q;
    ch_op   = CH_KEEP;
    capture = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (trig && !stop_ok) begin
          st_d  = ST_ISSUE;
          ch_op = CH_FIRST;
        end
      end
      ST_ISSUE: begin
        st_d = stop_ok ? ST_IDLE : ST_WAIT;
      end
      ST_WAIT: begin
        if (stop_ok) begin
          st_d = ST_IDLE;
        end else if (md == MODE_SHOT_RS && trig) begin
          st_d  = ST_ISSUE;
          ch_op = CH_FIRST;
        end else if (conv_done) begin
          capture = 1'b1;
          if (md == MODE_PAUSE) begin
            st_d = ST_HOLD;
          end else if (at_last && md != MODE_CONT) begin
            st_d = ST_IDLE;
          end else begin
            st_d  = ST_ISSUE;
            ch_op = CH_ADV;
          end
        end
      end
      ST_HOLD: begin
        if (stop_ok) begin
          st_d = ST_IDLE;
        end else if (trig) begin
          st_d  = ST_ISSUE;
          ch_op = CH_ADV;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign issue  = (st_q == ST_ISSUE);
  assign active = (st_q != ST_IDLE);
endmodule

// File: rtl/chan_ptr.sv
module chan_ptr
  import adc_scan_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ch_op_e          ch_op,
  input  logic [CH_W-1:0] first_ch,
  input  logic [CH_W-1:0] last_ch,
  output logic [CH_W-1:0] chan,
  output logic            at_last
);
  logic [CH_W-1:0] chan_q, chan_d;
  logic            chan_en;

  assign at_last = (chan_q == last_ch);
  assign chan_en = (ch_op != CH_KEEP);

  always_comb begin
    if (ch_op == CH_FIRST || at_last) chan_d = first_ch;
    else                              chan_d = chan_q + CH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chan_q <= '0;
    else if (chan_en) chan_q <= chan_d;
  end

  assign chan = chan_q;
endmodule

// File: rtl/result_latch.sv
module result_latch #(
  parameter int RES_W    = 10,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             capture,
  input  logic             res8,
  input  logic [RES_W-1:0] raw,
  output logic [RES_W-1:0] result,
  output logic             result_ok,
  output logic             done
);
  localparam int DROP = RES_W - NARROW_W;

  logic [RES_W-1:0] narrow;
  logic [RES_W-1:0] res_d;
  logic             res8_snap_q;
  logic [RES_W-1:0] result_q;
  logic             ok_q, done_q;

  generate
    if (DROP > 0) begin : g_narrow
      assign narrow = {{DROP{1'b0}}, raw[RES_W-1 -: NARROW_W]};
    end else begin : g_same
      assign narrow = raw;
    end
  endgenerate

  assign res_d = res8 ? narrow : raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     res8_snap_q <= 1'b0;
    else if (issue) res8_snap_q <= res8;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      ok_q     <= 1'b0;
    end else if (capture) begin
      result_q <= res_d;
      ok_q     <= (res8 == res8_snap_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= capture;
  end

  assign result    = result_q;
  assign result_ok = ok_q;
  assign done      = done_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CH_W     = 4,
  parameter int RES_W    = 10,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             res8,
  input  logic [CH_W-1:0]  first_ch,
  input  logic [CH_W-1:0]  last_ch,
  input  logic             sw_trig,
  input  logic             ext_trig,
  input  logic             busy_clr,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic [CH_W-1:0]  chan,
  output logic [RES_W-1:0] result,
  output logic             result_ok,
  output logic             done,
  output logic             busy
);
  logic   rst_n_s;
  logic   trig;
  logic   at_last;
  logic   capture;
  ch_op_e ch_op;

  assign trig = sw_trig | ext_trig;

  rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  scan_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .mode      (mode),
    .trig      (trig),
    .stop_req  (busy_clr),
    .conv_done (conv_done),
    .at_last   (at_last),
    .ch_op     (ch_op),
    .capture   (capture),
    .issue     (conv_start),
    .active    (busy)
  );

  chan_ptr #(.CH_W(CH_W)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ch_op    (ch_op),
    .first_ch (first_ch),
    .last_ch  (last_ch),
    .chan     (chan),
    .at_last  (at_last)
  );

  result_latch #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .issue     (conv_start),
    .capture   (capture),
    .res8      (res8),
    .raw       (conv_data),
    .result    (result),
    .result_ok (result_ok),
    .done      (done)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic [CH_W-1:0] first_ch,
  input logic            sw_trig,
  input logic            ext_trig,
  input logic            busy_clr,
  input logic            conv_start,
  input logic            conv_done,
  input logic [CH_W-1:0] chan,
  input logic            done,
  input logic            busy
);
  logic trig;
  assign trig = sw_trig | ext_trig;

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_start && mode == 2'b00 && trig) |=>
      (conv_start && chan == $past(first_ch)));

  p_trig_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_start && (mode == 2'b01 || mode == 2'b10) && trig
     && !conv_done && !busy_clr) |=> (!conv_start && $stable(chan)));

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_clr && mode[1]) |=> !busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .first_ch   (first_ch),
  .sw_trig    (sw_trig),
  .ext_trig   (ext_trig),
  .busy_clr   (busy_clr),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .chan       (chan),
  .done       (done),
  .busy       (busy)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       res8;
  logic [3:0] first_ch, last_ch;
  logic       sw_trig, ext_trig, busy_clr;
  logic       conv_start, conv_done;
  logic [9:0] conv_data;
  logic [3:0] chan;
  logic [9:0] result;
  logic       result_ok, done, busy;

  int checks = 0;
  int errors = 0;

  adc_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .res8(res8),
    .first_ch(first_ch), .last_ch(last_ch), .sw_trig(sw_trig),
    .ext_trig(ext_trig), .busy_clr(busy_clr), .conv_start(conv_start),
    .conv_done(conv_done), .conv_data(conv_data), .chan(chan),
    .result(result), .result_ok(result_ok), .done(done), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // converter model and done monitor
  logic [3:0] cur_ch = 4'd0;
  int         cnt = 0;
  int         nlog = 0;
  int         dbl = 0;
  logic       prev_done = 1'b0;
  logic [3:0] log_ch  [64];
  logic [9:0] log_res [64];
  logic       log_ok  [64];

  function automatic logic [9:0] mkdata(input logic [3:0] c);
    return {c, c ^ 4'h5, 2'b10};
  endfunction

  function automatic logic [9:0] fmt(input logic [3:0] c, input logic r8);
    logic [9:0] d;
    d = mkdata(c);
    return r8 ? {2'b00, d[9:2]} : d;
  endfunction

  always @(negedge clk) begin
    if (done) begin
      if (nlog < 64) begin
        log_ch[nlog]  = cur_ch;
        log_res[nlog] = result;
        log_ok[nlog]  = result_ok;
      end
      nlog++;
      if (prev_done) dbl++;
    end
    prev_done = done;
    if (conv_start) begin
      cur_ch = chan;
      cnt = 2 + (int'(chan) % 3);
      conv_done <= 1'b0;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        conv_done <= 1'b1;
        conv_data <= mkdata(cur_ch);
      end else begin
        conv_done <= 1'b0;
      end
    end else begin
      conv_done <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_trig(input bit use_ext);
    if (use_ext) ext_trig = 1'b1; else sw_trig = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0;
    sw_trig  = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_wait_on(input logic [3:0] c);
    for (int i = 0; i < 3000 && !(busy && !conv_start && chan == c); i++)
      @(negedge clk);
  endtask

  task automatic clear_log();
    nlog = 0;
    dbl  = 0;
  endtask

  // one single-shot scan, checked against arithmetic expectations
  task automatic run_shot(input logic [1:0] m, input int f, input int l, input logic r8);
    int  n, bad_seq, bad_res, bad_ok;
    mode = m; first_ch = 4'(f); last_ch = 4'(l); res8 = r8;
    clear_log();
    pulse_trig(f[0]);
    wait_idle();
    tick(1);
    n = ((l - f) & 15) + 1;
    bad_seq = 0; bad_res = 0; bad_ok = 0;
    for (int i = 0; i < n && i < 64; i++) begin
      if (log_ch[i] != 4'((f + i) & 15)) bad_seq++;
      if (log_res[i] != fmt(4'((f + i) & 15), r8)) bad_res++;
      if (!log_ok[i]) bad_ok++;
    end
    chk(nlog == n && bad_seq == 0, "R3/R12 sequence", nlog * 100 + bad_seq, n * 100);
    chk(bad_res == 0, "R9 result format", bad_res, 0);
    chk(bad_ok == 0 && dbl == 0, "R10/R11 ok flag and done pulse", bad_ok + dbl, 0);
    chk(!busy && !conv_start, "R3 idle after last", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int exp_seq[4];
    int bad;
    rst_n = 1'b0; mode = 2'b01; res8 = 1'b0; first_ch = 4'd0; last_ch = 4'd0;
    sw_trig = 1'b0; ext_trig = 1'b0; busy_clr = 1'b0;
    conv_done = 1'b0; conv_data = '0;
    tick(3);
    chk(!busy && !conv_start && !done && !result_ok && result == 0 && chan == 0,
        "R1 reset state", {busy, conv_start, done, result_ok}, 0);
    rst_n = 1'b1;
    tick(4);
    chk(!busy && chan == 0 && result == 0, "R1 after release", busy, 0);

    // R2: external trigger from idle
    mode = 2'b01; first_ch = 4'd9; last_ch = 4'd10;
    pulse_trig(1'b1);
    chk(conv_start && busy && chan == 4'd9, "R2 start on trigger", chan, 9);
    wait_idle(); tick(2);

    // R3, R9, R12: exhaustive start/end sweeps in both single-shot modes
    for (int f = 0; f < 16; f++)
      for (int l = 0; l < 16; l++)
        run_shot(2'b01, f, l, 1'(l & 1));
    for (int f = 0; f < 16; f++)
      for (int l = 0; l < 16; l++)
        run_shot(2'b00, f, l, 1'((f + l) & 1));

    // R4: restart in mode 00
    mode = 2'b00; first_ch = 4'd2; last_ch = 4'd6; res8 = 1'b0;
    clear_log();
    pulse_trig(1'b0);
    wait_wait_on(4'd4);
    pulse_trig(1'b0);
    chk(conv_start && chan == 4'd2, "R4 restart from first", chan, 2);
    wait_idle(); tick(1);
    chk(nlog == 7 && log_ch[2] == 4'd2 && log_ch[6] == 4'd6, "R4 restarted sequence", nlog, 7);

    // R5 and R8: mode 01 ignores triggers and busy-clear while scanning
    mode = 2'b01;
    clear_log();
    pulse_trig(1'b0);
    wait_wait_on(4'd4);
    pulse_trig(1'b1);
    chk(!conv_start && chan == 4'd4, "R5 trigger ignored in mode 01", chan, 4);
    busy_clr = 1'b1; @(negedge clk); busy_clr = 1'b0;
    chk(busy == 1'b1, "R8 busy_clr ignored in mode 01", busy, 1);
    wait_idle(); tick(1);
    chk(nlog == 5 && log_ch[0] == 4'd2 && log_ch[4] == 4'd6, "R5 sequence unchanged", nlog, 5);

    // R6: continuous with wrap across 15
    mode = 2'b10; first_ch = 4'd14; last_ch = 4'd1;
    clear_log();
    pulse_trig(1'b0);
    for (int i = 0; i < 3000 && nlog < 10; i++) @(negedge clk);
    wait_wait_on(chan);
    pulse_trig(1'b1);
    chk(!conv_start && busy, "R5 trigger ignored in mode 10", conv_start, 0);
    bad = 0;
    exp_seq = '{14, 15, 0, 1};
    for (int i = 0; i < 10; i++) if (log_ch[i] != 4'(exp_seq[i % 4])) bad++;
    chk(bad == 0 && busy, "R6 continuous wrap", bad, 0);
    // R8: stop wins over simultaneous trigger
    busy_clr = 1'b1; sw_trig = 1'b1;
    @(negedge clk);
    busy_clr = 1'b0; sw_trig = 1'b0;
    chk(!busy && !conv_start, "R8 stop in mode 10", busy, 0);
    tick(10);
    chk(!busy, "R8 stays idle", busy, 0);

    // R7: pause mode
    mode = 2'b11; first_ch = 4'd3; last_ch = 4'd5;
    clear_log();
    pulse_trig(1'b0);
    tick(30);
    chk(nlog == 1 && log_ch[0] == 4'd3 && busy && !conv_start, "R7 one channel then hold", nlog, 1);
    pulse_trig(1'b0);
    tick(1);
    pulse_trig(1'b1);
    chk(!conv_start && chan == 4'd4, "R5 trigger ignored in mode 11", chan, 4);
    tick(30);
    pulse_trig(1'b0); tick(30);
    pulse_trig(1'b1); tick(30);
    chk(nlog == 4 && log_ch[1] == 4'd4 && log_ch[2] == 4'd5 && log_ch[3] == 4'd3,
        "R7 step and wrap", nlog, 4);
    busy_clr = 1'b1; @(negedge clk); busy_clr = 1'b0;
    chk(!busy, "R8 stop in mode 11", busy, 0);

    // R10: resolution change mid-conversion
    mode = 2'b01; first_ch = 4'd7; last_ch = 4'd7; res8 = 1'b0;
    clear_log();
    pulse_trig(1'b0);
    tick(1);
    res8 = 1'b1;
    wait_idle(); tick(1);
    chk(nlog == 1 && log_ok[0] == 1'b0, "R10 invalid after res change", log_ok[0], 0);
    res8 = 1'b0;
    run_shot(2'b01, 7, 7, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule